// File: doc/BRIEF.md
# Load-Store Bus Bridge Controller

The bridge sits between a processor's local load/store bus and an internal peripheral bus. Each processor request carries a target space: the peripheral bus, a local-bus resource, or the bridge's own special registers. Requests aimed at the peripheral bus are checked against a violation flag that an external protection unit computes. A clean request becomes one peripheral-bus cycle. A violating request ends at once with an error response. Local-bus accesses can be copied onto the peripheral bus as marked show cycles, which makes them visible for debug. The bridge holds a single load-reserve/store-conditional reservation. Stores seen on either bus can cancel it, and the processor sees its state on `resv_flag`.

Soft and hard reset differ in effect. Both drive the matching local-side reset outputs and return the controller to idle. Only hard reset clears the control register and captures the configuration word from the peripheral side. In peripheral mode the processor port is shut and a separate external-master port takes over. That port reaches peripheral-bus slaves, local-bus slaves and, only while the continuation input is low, the special registers.

The controller has these states: `ST_IDLE`, `ST_FWD` (peripheral-bus cycle), `ST_SHOW` (mirrored cycle), `ST_LOCAL` (external master to a local slave) and `ST_RESP` (one-cycle response). It makes these transitions:
- IDLE to FWD, SHOW, LOCAL or RESP on acceptance, chosen by decode.
- FWD and SHOW to RESP on `pb_ready`.
- LOCAL to RESP on `ls_ready`.
- RESP to IDLE always.
- Any state to IDLE on either reset.

Top module: `lsb_bridge`

## Requirements
- R1: A processor request with space code 0 (peripheral bus) and `prot_viol` low produces exactly one peripheral-bus cycle with `pb_show`=0, carrying the request's address, direction and write data. A read returns `pb_rdata` on `r_rdata`.
- R2: No peripheral-bus cycle occurs, and the response has `r_error`=1, in two cases:
  - a processor request with space 0 and `prot_viol` high;
  - any request with space code 3.
  Requests with space codes 1 and 2 ignore `prot_viol`.
- R3: Special register address bit 0 = 0 is the control register, and its bit 0 enables show cycles.
  - While that bit is set, a processor request with space code 1 (local resource) produces one peripheral-bus cycle with `pb_show`=1.
  - While it is clear, no cycle occurs.
  - Either way the response has no error and zero data.
- R4: A processor read with kind code 1 (load-reserve) that completes on the peripheral bus sets `resv_flag` and records its address.
- R5: A store with a matching address clears `resv_flag` one cycle later. Such a store can come from the peripheral-bus snoop port, the local-bus snoop port, or an external-master store forwarded by the bridge. Reads and stores to other addresses leave the flag unchanged.
- R6: A processor store with kind code 2 (store-conditional) is forwarded only if the reservation is set for its address.
  - When forwarded, it responds `r_sc_ok`=1 and clears the reservation.
  - Otherwise no cycle occurs and the response has `r_sc_ok`=0 and `r_error`=0.
- R7: `lb_hard_rst_n` and `lb_soft_rst_n` are low exactly while `hard_rst_n` and `soft_rst_n` respectively are low.
- R8: Soft reset returns the controller to idle. It drops an in-flight access with no response, and it clears the reservation. The control register keeps its value.
- R9: While `hard_rst_n` is low, `lb_cfg_word` follows `pb_cfg_word` and that value is captured. After release, `lb_cfg_word` holds the capture and special register address 1 reads it back. Writes to address 1 are ignored. Hard reset clears the control register to 0.
- R10: While `periph_mode` is high, `lq_ready` stays low. External-master requests reach peripheral-bus slaves without the protection check, and reach local-bus slaves through the `ls_*` port.
- R11: An external-master request with space code 2 while `cont_bit` is high responds with `r_error`=1 and does not change the registers.
- R12: Between acceptance and response the request ready stays low. Each response holds `r_valid` high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Hard reset from the peripheral side, active low |
| soft_rst_n | input | 1 | Soft reset from the peripheral side, active low |
| lb_hard_rst_n | output | 1 | Hard reset toward the local bus |
| lb_soft_rst_n | output | 1 | Soft reset toward the local bus |
| pb_cfg_word | input | DW | Configuration word from the peripheral side |
| lb_cfg_word | output | DW | Configuration word toward the local bus |
| periph_mode | input | 1 | Selects the external-master port |
| cont_bit | input | 1 | When high, blocks external access to special registers |
| lq_valid | input | 1 | Processor request valid |
| lq_ready | output | 1 | Processor request accepted |
| lq_write | input | 1 | Processor request is a store |
| lq_space | input | 2 | 0 peripheral bus, 1 local resource, 2 special register, 3 reserved |
| lq_kind | input | 2 | 0 plain, 1 load-reserve, 2 store-conditional |
| lq_addr | input | AW | Processor address |
| lq_wdata | input | DW | Processor store data |
| prot_viol | input | 1 | Protection violation for the current processor request |
| xq_valid | input | 1 | External-master request valid |
| xq_ready | output | 1 | External-master request accepted |
| xq_write | input | 1 | External-master request is a store |
| xq_space | input | 2 | Same coding as lq_space |
| xq_addr | input | AW | External-master address |
| xq_wdata | input | DW | External-master store data |
| r_valid | output | 1 | Response valid |
| r_error | output | 1 | Response carries an error |
| r_sc_ok | output | 1 | Store-conditional succeeded |
| r_rdata | output | DW | Read data |
| resv_flag | output | 1 | Reservation held |
| pb_valid | output | 1 | Peripheral-bus cycle valid |
| pb_ready | input | 1 | Peripheral-bus cycle complete |
| pb_write | output | 1 | Peripheral-bus cycle is a store |
| pb_show | output | 1 | Cycle is a mirrored local access |
| pb_addr | output | AW | Peripheral-bus address |
| pb_wdata | output | DW | Peripheral-bus store data |
| pb_rdata | input | DW | Peripheral-bus read data |
| pb_snp_valid | input | 1 | Other-master activity on the peripheral bus |
| pb_snp_write | input | 1 | That activity is a store |
| pb_snp_addr | input | AW | Its address |
| lb_snp_valid | input | 1 | Other-master activity on the local bus |
| lb_snp_write | input | 1 | That activity is a store |
| lb_snp_addr | input | AW | Its address |
| ls_valid | output | 1 | Local-slave cycle valid |
| ls_ready | input | 1 | Local-slave cycle complete |
| ls_write | output | 1 | Local-slave cycle is a store |
| ls_addr | output | AW | Local-slave address |
| ls_wdata | output | DW | Local-slave store data |
| ls_rdata | input | DW | Local-slave read data |

## Verification
The hardest situation to reach is a soft reset that lands while a forwarded access is stalled, with a live reservation and a non-default control register all at once. The bench first writes the control register and takes a reservation. It then holds its peripheral-bus model's ready low, so the controller stays in `ST_FWD` when soft reset is pulsed. Afterwards it confirms three things: no response ever appears, the flag has dropped, and the control value survived. Reservation loss is exercised separately from each of the three store sources, with non-matching addresses and reads used as negative cases.

// File: rtl/lsb_pkg.sv
package lsb_pkg;

    typedef enum logic [1:0] {
        SP_PERIPH = 2'd0,
        SP_LOCAL  = 2'd1,
        SP_SREG   = 2'd2,
        SP_RSVD   = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        K_PLAIN  = 2'd0,
        K_LRES   = 2'd1,
        K_SCOND  = 2'd2,
        K_SPARE  = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FWD   = 3'd1,
        ST_SHOW  = 3'd2,
        ST_LOCAL = 3'd3,
        ST_RESP  = 3'd4
    } state_e;

    typedef struct packed {
        logic   ext;
        logic   write;
        space_e space;
        kind_e  kind;
    } ctl_t;

endpackage

// File: rtl/lsb_regs.sv
module lsb_regs #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          hard_rst_n,
    input  logic          we,
    input  logic          sel,
    input  logic          wbit,
    input  logic [DW-1:0] pb_cfg_word,
    output logic          show_en,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] lb_cfg_word
);

    logic          show_q;
    logic [DW-1:0] cfg_q;

    // Only hard reset touches these; soft reset leaves them alone.
    always_ff @(posedge clk) begin
        if (!hard_rst_n) begin
            show_q <= 1'b0;
            cfg_q  <= pb_cfg_word;
        end else if (we && !sel) begin
            show_q <= wbit;
        end
    end

    always_comb begin
        show_en     = show_q;
        rdata       = sel ? cfg_q : {{(DW-1){1'b0}}, show_q};
        lb_cfg_word = hard_rst_n ? cfg_q : pb_cfg_word;
    end

    assert_cfg_readonly_R9: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (we && sel) |=> $stable(cfg_q));

endmodule

// File: rtl/lsb_resv.sv
module lsb_resv #(
    parameter int AW   = 16,
    parameter int NSRC = 3
) (
    input  logic          clk,
    input  logic          hard_rst_n,
    input  logic          soft_rst_n,
    input  logic          set_en,
    input  logic [AW-1:0] set_addr,
    input  logic          sc_done,
    input  logic          snp_valid [NSRC],
    input  logic          snp_write [NSRC],
    input  logic [AW-1:0] snp_addr  [NSRC],
    input  logic [AW-1:0] chk_addr,
    output logic          resv_flag,
    output logic          sc_hit
);

    logic            held_q;
    logic [AW-1:0]   addr_q;
    logic [AW-1:0]   eff_addr;
    logic [NSRC-1:0] kill;

    assign eff_addr = set_en ? set_addr : addr_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign kill[i] = snp_valid[i] && snp_write[i] && (snp_addr[i] == eff_addr);

        assert_snoop_kill_R5: assert property (@(posedge clk)
            disable iff (!hard_rst_n || !soft_rst_n)
            (held_q && !set_en && snp_valid[i] && snp_write[i] && snp_addr[i] == addr_q)
            |=> !resv_flag);
    end

    always_ff @(posedge clk) begin
        if (!hard_rst_n || !soft_rst_n) begin
            held_q <= 1'b0;
            addr_q <= '0;
        end else begin
            if (set_en) begin
                held_q <= 1'b1;
                addr_q <= set_addr;
            end
            if (sc_done || (|kill)) begin
                held_q <= 1'b0;
            end
        end
    end

    assign resv_flag = held_q;
    assign sc_hit    = held_q && (addr_q == chk_addr);

endmodule

// File: rtl/lsb_fsm.sv
module lsb_fsm
    import lsb_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          hard_rst_n,
    input  logic          soft_rst_n,
    input  logic          in_valid,
    input  ctl_t          in_ctl,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_wdata,
    input  logic          in_viol,
    output logic          in_ready,
    input  logic          show_en,
    input  logic          cont_bit,
    input  logic          sc_hit,
    input  logic [DW-1:0] reg_rdata,
    output logic          reg_we,
    output logic          pb_valid,
    input  logic          pb_ready,
    output logic          pb_write,
    output logic          pb_show,
    output logic [AW-1:0] pb_addr,
    output logic [DW-1:0] pb_wdata,
    input  logic [DW-1:0] pb_rdata,
    output logic          ls_valid,
    input  logic          ls_ready,
    output logic          ls_write,
    output logic [AW-1:0] ls_addr,
    output logic [DW-1:0] ls_wdata,
    input  logic [DW-1:0] ls_rdata,
    output logic          r_valid,
    output logic          r_error,
    output logic          r_sc_ok,
    output logic [DW-1:0] r_rdata,
    output logic          resv_set,
    output logic          resv_sc,
    output logic          ext_store
);

    state_e        state_q, state_d;
    ctl_t          ctl_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q, rdata_q;
    logic          err_q, sc_q;
    logic          take, fault_in, sc_req_in, rst_any;

    assign rst_any   = !hard_rst_n || !soft_rst_n;
    assign take      = (state_q == ST_IDLE) && in_valid;
    assign sc_req_in = (in_ctl.kind == K_SCOND) && in_ctl.write;
    assign fault_in  = ((in_ctl.space == SP_PERIPH) && !in_ctl.ext && in_viol)
                    || (in_ctl.space == SP_RSVD)
                    || ((in_ctl.space == SP_SREG) && in_ctl.ext && cont_bit);

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    unique case (in_ctl.space)
                        SP_PERIPH: state_d = (fault_in || (sc_req_in && !sc_hit)) ? ST_RESP : ST_FWD;
                        SP_LOCAL:  state_d = in_ctl.ext ? ST_LOCAL : (show_en ? ST_SHOW : ST_RESP);
                        default:   state_d = ST_RESP;
                    endcase
                end
            end
            ST_FWD:   if (pb_ready) state_d = ST_RESP;
            ST_SHOW:  if (pb_ready) state_d = ST_RESP;
            ST_LOCAL: if (ls_ready) state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst_any) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Request and response holding registers
    always_ff @(posedge clk) begin
        if (rst_any) begin
            ctl_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
            sc_q    <= 1'b0;
        end else begin
            if (take) begin
                ctl_q   <= in_ctl;
                addr_q  <= in_addr;
                wdata_q <= in_wdata;
                err_q   <= fault_in;
                sc_q    <= 1'b0;
                rdata_q <= (in_ctl.space == SP_SREG && !in_ctl.write && !fault_in) ? reg_rdata : '0;
            end
            if (state_q == ST_FWD && pb_ready) begin
                if (!ctl_q.write) rdata_q <= pb_rdata;
                if (ctl_q.write && ctl_q.kind == K_SCOND) sc_q <= 1'b1;
            end
            if (state_q == ST_LOCAL && ls_ready && !ctl_q.write) begin
                rdata_q <= ls_rdata;
            end
        end
    end

    // Outputs
    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        pb_valid  = (state_q == ST_FWD) || (state_q == ST_SHOW);
        pb_show   = (state_q == ST_SHOW);
        pb_write  = ctl_q.write;
        pb_addr   = addr_q;
        pb_wdata  = wdata_q;
        ls_valid  = (state_q == ST_LOCAL);
        ls_write  = ctl_q.write;
        ls_addr   = addr_q;
        ls_wdata  = wdata_q;
        r_valid   = (state_q == ST_RESP);
        r_error   = err_q;
        r_sc_ok   = sc_q;
        r_rdata   = rdata_q;
        reg_we    = take && (in_ctl.space == SP_SREG) && in_ctl.write && !fault_in;
        resv_set  = (state_q == ST_FWD) && pb_ready && !ctl_q.ext
                 && (ctl_q.kind == K_LRES) && !ctl_q.write;
        resv_sc   = (state_q == ST_FWD) && pb_ready && (ctl_q.kind == K_SCOND) && ctl_q.write;
        ext_store = (state_q == ST_FWD) && pb_ready && ctl_q.ext && ctl_q.write;
    end

    assert_viol_blocked_R2: assert property (@(posedge clk) disable iff (rst_any)
        (take && in_ctl.space == SP_PERIPH && !in_ctl.ext && in_viol)
        |=> (r_valid && r_error && !pb_valid));

    assert_pb_hold_R1: assert property (@(posedge clk) disable iff (rst_any)
        (pb_valid && !pb_ready) |=> (pb_valid && $stable(pb_addr) && $stable(pb_write)));

    assert_sreg_locked_R11: assert property (@(posedge clk) disable iff (rst_any)
        (take && in_ctl.ext && in_ctl.space == SP_SREG && cont_bit) |=> (r_valid && r_error));

    assert_soft_idle_R8: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (!soft_rst_n) |=> (!pb_valid && !ls_valid && !r_valid));

    assert_busy_R12: assert property (@(posedge clk) disable iff (rst_any)
        r_valid |=> !r_valid);

endmodule

// File: rtl/lsb_bridge.sv
module lsb_bridge
    import lsb_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          hard_rst_n,
    input  logic          soft_rst_n,
    output logic          lb_hard_rst_n,
    output logic          lb_soft_rst_n,
    input  logic [DW-1:0] pb_cfg_word,
    output logic [DW-1:0] lb_cfg_word,
    input  logic          periph_mode,
    input  logic          cont_bit,
    input  logic          lq_valid,
    output logic          lq_ready,
    input  logic          lq_write,
    input  logic [1:0]    lq_space,
    input  logic [1:0]    lq_kind,
    input  logic [AW-1:0] lq_addr,
    input  logic [DW-1:0] lq_wdata,
    input  logic          prot_viol,
    input  logic          xq_valid,
    output logic          xq_ready,
    input  logic          xq_write,
    input  logic [1:0]    xq_space,
    input  logic [AW-1:0] xq_addr,
    input  logic [DW-1:0] xq_wdata,
    output logic          r_valid,
    output logic          r_error,
    output logic          r_sc_ok,
    output logic [DW-1:0] r_rdata,
    output logic          resv_flag,
    output logic          pb_valid,
    input  logic          pb_ready,
    output logic          pb_write,
    output logic          pb_show,
    output logic [AW-1:0] pb_addr,
    output logic [DW-1:0] pb_wdata,
    input  logic [DW-1:0] pb_rdata,
    input  logic          pb_snp_valid,
    input  logic          pb_snp_write,
    input  logic [AW-1:0] pb_snp_addr,
    input  logic          lb_snp_valid,
    input  logic          lb_snp_write,
    input  logic [AW-1:0] lb_snp_addr,
    output logic          ls_valid,
    input  logic          ls_ready,
    output logic          ls_write,
    output logic [AW-1:0] ls_addr,
    output logic [DW-1:0] ls_wdata,
    input  logic [DW-1:0] ls_rdata
);

    localparam int NSRC = 3;

    ctl_t          in_ctl;
    logic          in_valid, in_ready, in_viol;
    logic [AW-1:0] in_addr;
    logic [DW-1:0] in_wdata;
    logic          show_en, reg_we, sc_hit;
    logic          resv_set, resv_sc, ext_store;
    logic [DW-1:0] reg_rdata;
    logic          snp_v [NSRC];
    logic          snp_w [NSRC];
    logic [AW-1:0] snp_a [NSRC];

    assign lb_hard_rst_n = hard_rst_n;
    assign lb_soft_rst_n = soft_rst_n;

    // Request source select: processor normally, external master in peripheral mode
    assign in_valid     = periph_mode ? xq_valid : lq_valid;
    assign in_ctl.ext   = periph_mode;
    assign in_ctl.write = periph_mode ? xq_write : lq_write;
    assign in_ctl.space = space_e'(periph_mode ? xq_space : lq_space);
    assign in_ctl.kind  = periph_mode ? K_PLAIN : kind_e'(lq_kind);
    assign in_addr      = periph_mode ? xq_addr : lq_addr;
    assign in_wdata     = periph_mode ? xq_wdata : lq_wdata;
    assign in_viol      = !periph_mode && prot_viol;
    assign lq_ready     = in_ready && !periph_mode;
    assign xq_ready     = in_ready && periph_mode;

    // Store sources that cancel the reservation
    assign snp_v[0] = pb_snp_valid;
    assign snp_w[0] = pb_snp_write;
    assign snp_a[0] = pb_snp_addr;
    assign snp_v[1] = lb_snp_valid;
    assign snp_w[1] = lb_snp_write;
    assign snp_a[1] = lb_snp_addr;
    assign snp_v[2] = ext_store;
    assign snp_w[2] = 1'b1;
    assign snp_a[2] = pb_addr;

    lsb_regs #(.DW(DW)) u_regs (
        .clk         (clk),
        .hard_rst_n  (hard_rst_n),
        .we          (reg_we),
        .sel         (in_addr[0]),
        .wbit        (in_wdata[0]),
        .pb_cfg_word (pb_cfg_word),
        .show_en     (show_en),
        .rdata       (reg_rdata),
        .lb_cfg_word (lb_cfg_word)
    );

    lsb_resv #(.AW(AW), .NSRC(NSRC)) u_resv (
        .clk        (clk),
        .hard_rst_n (hard_rst_n),
        .soft_rst_n (soft_rst_n),
        .set_en     (resv_set),
        .set_addr   (pb_addr),
        .sc_done    (resv_sc),
        .snp_valid  (snp_v),
        .snp_write  (snp_w),
        .snp_addr   (snp_a),
        .chk_addr   (in_addr),
        .resv_flag  (resv_flag),
        .sc_hit     (sc_hit)
    );

    lsb_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk        (clk),
        .hard_rst_n (hard_rst_n),
        .soft_rst_n (soft_rst_n),
        .in_valid   (in_valid),
        .in_ctl     (in_ctl),
        .in_addr    (in_addr),
        .in_wdata   (in_wdata),
        .in_viol    (in_viol),
        .in_ready   (in_ready),
        .show_en    (show_en),
        .cont_bit   (cont_bit),
        .sc_hit     (sc_hit),
        .reg_rdata  (reg_rdata),
        .reg_we     (reg_we),
        .pb_valid   (pb_valid),
        .pb_ready   (pb_ready),
        .pb_write   (pb_write),
        .pb_show    (pb_show),
        .pb_addr    (pb_addr),
        .pb_wdata   (pb_wdata),
        .pb_rdata   (pb_rdata),
        .ls_valid   (ls_valid),
        .ls_ready   (ls_ready),
        .ls_write   (ls_write),
        .ls_addr    (ls_addr),
        .ls_wdata   (ls_wdata),
        .ls_rdata   (ls_rdata),
        .r_valid    (r_valid),
        .r_error    (r_error),
        .r_sc_ok    (r_sc_ok),
        .r_rdata    (r_rdata),
        .resv_set   (resv_set),
        .resv_sc    (resv_sc),
        .ext_store  (ext_store)
    );

endmodule

// File: tb/lsb_bridge_tb.sv
module lsb_bridge_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        hard_rst_n = 1'b0, soft_rst_n = 1'b1;
    logic        lb_hard_rst_n, lb_soft_rst_n;
    logic [15:0] pb_cfg_word = 16'hC3A1, lb_cfg_word;
    logic        periph_mode = 1'b0, cont_bit = 1'b0;
    logic        lq_valid = 1'b0, lq_ready, lq_write = 1'b0;
    logic [1:0]  lq_space = 2'd0, lq_kind = 2'd0;
    logic [15:0] lq_addr = '0, lq_wdata = '0;
    logic        prot_viol = 1'b0;
    logic        xq_valid = 1'b0, xq_ready, xq_write = 1'b0;
    logic [1:0]  xq_space = 2'd0;
    logic [15:0] xq_addr = '0, xq_wdata = '0;
    logic        r_valid, r_error, r_sc_ok, resv_flag;
    logic [15:0] r_rdata;
    logic        pb_valid, pb_ready = 1'b0, pb_write, pb_show;
    logic [15:0] pb_addr, pb_wdata, pb_rdata = '0;
    logic        pb_snp_valid = 1'b0, pb_snp_write = 1'b0;
    logic [15:0] pb_snp_addr = '0;
    logic        lb_snp_valid = 1'b0, lb_snp_write = 1'b0;
    logic [15:0] lb_snp_addr = '0;
    logic        ls_valid, ls_ready = 1'b0, ls_write;
    logic [15:0] ls_addr, ls_wdata, ls_rdata = '0;

    int checks = 0, errors = 0;
    int pb_cnt = 0, rv_cnt = 0, rv_run = 0, rv_run_max = 0;
    logic        pb_hold = 1'b0;
    logic        last_show, last_write, ls_last_w;
    logic [15:0] last_addr, last_wdata, ls_last_d;
    logic        got_err, got_sc;
    logic [15:0] got_data;
    logic        show_m = 1'b0, resv_m = 1'b0;
    logic [15:0] resv_a_m = '0, cfg_m = 16'hC3A1;
    bit          finished = 1'b0;

    lsb_bridge u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Simple slave models, driven away from the active edge
    always @(negedge clk) begin
        pb_ready = pb_valid && !pb_hold;
        pb_rdata = pb_addr ^ 16'h5A3C;
        ls_ready = ls_valid;
        ls_rdata = ls_addr + 16'd1;
    end

    always @(posedge clk) begin
        if (pb_valid && pb_ready) begin
            pb_cnt++;
            last_show  = pb_show;
            last_write = pb_write;
            last_addr  = pb_addr;
            last_wdata = pb_wdata;
        end
        if (ls_valid && ls_ready) begin
            ls_last_w = ls_write;
            ls_last_d = ls_wdata;
        end
        if (r_valid) begin
            rv_cnt++;
            rv_run++;
            if (rv_run > rv_run_max) rv_run_max = rv_run;
        end else begin
            rv_run = 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic op(input logic ext, input logic w, input logic [1:0] sp, input logic [1:0] k,
                      input logic [15:0] a, input logic [15:0] d, input logic v);
        int n;
        @(negedge clk);
        if (ext) begin
            xq_valid = 1'b1; xq_write = w; xq_space = sp; xq_addr = a; xq_wdata = d;
        end else begin
            lq_valid = 1'b1; lq_write = w; lq_space = sp; lq_kind = k; lq_addr = a; lq_wdata = d;
        end
        prot_viol = v;
        n = 0;
        while (!(ext ? xq_ready : lq_ready) && n < 50) begin @(negedge clk); n++; end
        @(negedge clk);
        xq_valid = 1'b0; lq_valid = 1'b0; prot_viol = 1'b0;
        n = 0;
        while (!r_valid && n < 50) begin @(negedge clk); n++; end
        got_err = r_error; got_sc = r_sc_ok; got_data = r_rdata;
        @(negedge clk);
    endtask

    task automatic do_hard_reset(input logic [15:0] cw);
        @(negedge clk);
        hard_rst_n = 1'b0;
        pb_cfg_word = cw;
        repeat (3) @(negedge clk);
        chk("R7 lb_hard_rst_n low", {31'd0, lb_hard_rst_n}, 32'd0);
        chk("R7 lb_soft_rst_n idle", {31'd0, lb_soft_rst_n}, 32'd1);
        chk("R9 cfg passes during reset", {16'd0, lb_cfg_word}, {16'd0, cw});
        hard_rst_n = 1'b1;
        cfg_m = cw; show_m = 1'b0; resv_m = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // Reset state
        repeat (3) @(negedge clk);
        chk("R7 lb_hard_rst_n in reset", {31'd0, lb_hard_rst_n}, 32'd0);
        chk("R9 cfg passes during reset", {16'd0, lb_cfg_word}, 32'h0000C3A1);
        hard_rst_n = 1'b1;
        @(negedge clk);
        chk("R7 lb_hard_rst_n released", {31'd0, lb_hard_rst_n}, 32'd1);
        chk("R12 ready after reset", {31'd0, lq_ready}, 32'd1);
        chk("R1 no pb cycle after reset", {31'd0, pb_valid}, 32'd0);
        chk("R4 no reservation after reset", {31'd0, resv_flag}, 32'd0);
        pb_cfg_word = 16'h0000;
        @(negedge clk);
        chk("R9 cfg word held after release", {16'd0, lb_cfg_word}, 32'h0000C3A1);

        // Near-exhaustive sweep of processor requests
        for (int sh = 0; sh < 2; sh++) begin
            op(1'b0, 1'b1, 2'd2, 2'd0, 16'h0000, 16'(sh), 1'b0);
            show_m = sh[0];
            for (int sp = 0; sp < 4; sp++)
            for (int k = 0; k < 3; k++)
            for (int w = 0; w < 2; w++)
            for (int v = 0; v < 2; v++) begin
                logic [15:0] a, d, e_data;
                logic        e_err, e_sc, e_pb;
                int          pb0;
                string       tag;
                a = 16'h4000 + 16'(sp * 16 + k * 4 + w * 2 + v);
                d = a ^ 16'h0F0F ^ 16'(sh);
                e_err = 1'b0; e_sc = 1'b0; e_pb = 1'b0; e_data = '0;
                case (sp)
                    0: begin
                        tag = v ? "R2" : ((k == 2 && w == 1) ? "R6" : "R1");
                        if (v) e_err = 1'b1;
                        else if (k == 2 && w == 1) begin
                            if (resv_m && resv_a_m == a) begin e_pb = 1'b1; e_sc = 1'b1; resv_m = 1'b0; end
                        end else begin
                            e_pb = 1'b1;
                            if (w == 0) e_data = a ^ 16'h5A3C;
                            if (k == 1 && w == 0) begin resv_m = 1'b1; resv_a_m = a; end
                        end
                    end
                    1: begin tag = "R3"; e_pb = show_m; end
                    2: begin
                        tag = "R9";
                        if (w == 1) begin if (a[0] == 1'b0) show_m = d[0]; end
                        else e_data = a[0] ? cfg_m : {15'd0, show_m};
                    end
                    default: begin tag = "R2"; e_err = 1'b1; end
                endcase
                pb0 = pb_cnt;
                op(1'b0, w[0], sp[1:0], k[1:0], a, d, v[0]);
                chk({tag, " error"}, {31'd0, got_err}, {31'd0, e_err});
                chk({tag, " sc_ok"}, {31'd0, got_sc}, {31'd0, e_sc});
                chk({tag, " data"}, {16'd0, got_data}, {16'd0, e_data});
                chk({tag, " pb cycles"}, 32'(pb_cnt - pb0), {31'd0, e_pb});
                if (e_pb) begin
                    chk({tag, " show marker"}, {31'd0, last_show}, {31'd0, sp == 1});
                    chk({tag, " pb addr"}, {16'd0, last_addr}, {16'd0, a});
                    if (w == 1) chk({tag, " pb wdata"}, {16'd0, last_wdata}, {16'd0, d});
                end
                chk("R4 reservation flag", {31'd0, resv_flag}, {31'd0, resv_m});
            end
        end

        // Reservation directed cases
        op(1'b0, 1'b0, 2'd0, 2'd1, 16'h0100, 16'h0, 1'b0);
        chk("R4 load-reserve sets flag", {31'd0, resv_flag}, 32'd1);
        @(negedge clk); pb_snp_valid = 1'b1; pb_snp_write = 1'b0; pb_snp_addr = 16'h0100;
        @(negedge clk); pb_snp_valid = 1'b0;
        chk("R5 snooped read keeps flag", {31'd0, resv_flag}, 32'd1);
        lb_snp_valid = 1'b1; lb_snp_write = 1'b1; lb_snp_addr = 16'h0101;
        @(negedge clk); lb_snp_valid = 1'b0;
        chk("R5 other-address store keeps flag", {31'd0, resv_flag}, 32'd1);
        lb_snp_valid = 1'b1; lb_snp_addr = 16'h0100;
        @(negedge clk); lb_snp_valid = 1'b0;
        chk("R5 local store clears flag", {31'd0, resv_flag}, 32'd0);
        begin
            int pb0;
            pb0 = pb_cnt;
            op(1'b0, 1'b1, 2'd0, 2'd2, 16'h0100, 16'hBEEF, 1'b0);
            chk("R6 sc fail no cycle", 32'(pb_cnt - pb0), 32'd0);
            chk("R6 sc fail flag", {31'd0, got_sc}, 32'd0);
            chk("R6 sc fail no error", {31'd0, got_err}, 32'd0);
        end
        op(1'b0, 1'b0, 2'd0, 2'd1, 16'h0100, 16'h0, 1'b0);
        @(negedge clk); pb_snp_valid = 1'b1; pb_snp_write = 1'b1; pb_snp_addr = 16'h0100;
        @(negedge clk); pb_snp_valid = 1'b0;
        chk("R5 peripheral store clears flag", {31'd0, resv_flag}, 32'd0);
        op(1'b0, 1'b0, 2'd0, 2'd1, 16'h0100, 16'h0, 1'b0);
        begin
            int pb0;
            pb0 = pb_cnt;
            op(1'b0, 1'b1, 2'd0, 2'd2, 16'h0100, 16'hBEEF, 1'b0);
            chk("R6 sc success cycle", 32'(pb_cnt - pb0), 32'd1);
            chk("R6 sc success data", {16'd0, last_wdata}, 32'h0000BEEF);
            chk("R6 sc success flag", {31'd0, got_sc}, 32'd1);
            chk("R6 sc clears reservation", {31'd0, resv_flag}, 32'd0);
        end

        // Soft reset with an access stalled in flight
        op(1'b0, 1'b1, 2'd2, 2'd0, 16'h0000, 16'h0001, 1'b0);
        op(1'b0, 1'b0, 2'd0, 2'd1, 16'h0200, 16'h0, 1'b0);
        pb_hold = 1'b1;
        @(negedge clk);
        lq_valid = 1'b1; lq_write = 1'b0; lq_space = 2'd0; lq_kind = 2'd0; lq_addr = 16'h0222;
        @(negedge clk);
        lq_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R12 busy while in flight", {31'd0, lq_ready}, 32'd0);
        chk("R1 cycle stalled", {31'd0, pb_valid}, 32'd1);
        begin
            int rv0;
            rv0 = rv_cnt;
            soft_rst_n = 1'b0;
            #1;
            chk("R7 lb_soft_rst_n follows", {31'd0, lb_soft_rst_n}, 32'd0);
            chk("R7 lb_hard_rst_n untouched", {31'd0, lb_hard_rst_n}, 32'd1);
            @(negedge clk);
            chk("R8 cycle dropped", {31'd0, pb_valid}, 32'd0);
            @(negedge clk);
            soft_rst_n = 1'b1; pb_hold = 1'b0;
            repeat (3) @(negedge clk);
            chk("R8 no response for dropped access", 32'(rv_cnt - rv0), 32'd0);
            chk("R8 reservation cleared", {31'd0, resv_flag}, 32'd0);
            chk("R8 ready again", {31'd0, lq_ready}, 32'd1);
        end
        op(1'b0, 1'b0, 2'd2, 2'd0, 16'h0000, 16'h0, 1'b0);
        chk("R8 control kept over soft reset", {16'd0, got_data}, 32'd1);
        op(1'b0, 1'b0, 2'd2, 2'd0, 16'h0001, 16'h0, 1'b0);
        chk("R9 cfg kept over soft reset", {16'd0, got_data}, {16'd0, cfg_m});

        // Hard reset clears control, captures a new word
        do_hard_reset(16'h7E11);
        op(1'b0, 1'b0, 2'd2, 2'd0, 16'h0000, 16'h0, 1'b0);
        chk("R9 control cleared by hard reset", {16'd0, got_data}, 32'd0);
        op(1'b0, 1'b1, 2'd2, 2'd0, 16'h0001, 16'h1234, 1'b0);
        op(1'b0, 1'b0, 2'd2, 2'd0, 16'h0001, 16'h0, 1'b0);
        chk("R9 cfg read-only", {16'd0, got_data}, 32'h00007E11);

        // Peripheral mode
        periph_mode = 1'b1;
        begin
            int pb0, rv0;
            pb0 = pb_cnt; rv0 = rv_cnt;
            @(negedge clk);
            lq_valid = 1'b1; lq_space = 2'd0; lq_write = 1'b0; lq_addr = 16'h0055;
            repeat (4) begin
                @(negedge clk);
                chk("R10 processor blocked", {31'd0, lq_ready}, 32'd0);
            end
            lq_valid = 1'b0;
            chk("R10 blocked processor no cycle", 32'(pb_cnt - pb0), 32'd0);
            chk("R10 blocked processor no response", 32'(rv_cnt - rv0), 32'd0);
        end
        op(1'b1, 1'b0, 2'd0, 2'd0, 16'h0440, 16'h0, 1'b1);
        chk("R10 external ignores protection", {31'd0, got_err}, 32'd0);
        chk("R10 external pb read", {16'd0, got_data}, {16'd0, 16'h0440 ^ 16'h5A3C});
        op(1'b1, 1'b0, 2'd1, 2'd0, 16'h0033, 16'h0, 1'b0);
        chk("R10 external local read", {16'd0, got_data}, 32'h00000034);
        op(1'b1, 1'b1, 2'd1, 2'd0, 16'h0034, 16'hA5A5, 1'b0);
        chk("R10 external local write", {15'd0, ls_last_w, ls_last_d}, 32'h0001A5A5);
        cont_bit = 1'b1;
        op(1'b1, 1'b1, 2'd2, 2'd0, 16'h0000, 16'h0001, 1'b0);
        chk("R11 locked register error", {31'd0, got_err}, 32'd1);
        cont_bit = 1'b0;
        op(1'b1, 1'b0, 2'd2, 2'd0, 16'h0000, 16'h0, 1'b0);
        chk("R11 locked write had no effect", {16'd0, got_data}, 32'd0);
        op(1'b1, 1'b1, 2'd2, 2'd0, 16'h0000, 16'h0001, 1'b0);
        chk("R11 unlocked write ok", {31'd0, got_err}, 32'd0);
        op(1'b1, 1'b0, 2'd2, 2'd0, 16'h0000, 16'h0, 1'b0);
        chk("R11 unlocked write took effect", {16'd0, got_data}, 32'd1);
        periph_mode = 1'b0;
        op(1'b0, 1'b0, 2'd0, 2'd1, 16'h0300, 16'h0, 1'b0);
        chk("R4 reservation before external store", {31'd0, resv_flag}, 32'd1);
        periph_mode = 1'b1;
        op(1'b1, 1'b1, 2'd0, 2'd0, 16'h0300, 16'h1111, 1'b0);
        chk("R5 external store clears flag", {31'd0, resv_flag}, 32'd0);
        periph_mode = 1'b0;

        chk("R12 response lasts one cycle", 32'(rv_run_max), 32'd1);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule